// File: doc/BRIEF.md
# Masked Configuration Readback Verifier

This block checks the configuration memory of a target FPGA while the device runs. A readback engine delivers the device's configuration image one byte per transfer. A flash reader supplies two reference streams in step with it: a golden copy of the bitstream and a mask. The mask marks the bits whose readback value can be compared. Bits that change while the device runs, such as memory contents and flip-flop state, are masked out. Each byte triplet is judged by one rule: the golden byte must equal the readback byte ANDed with the mask byte.

A failing byte raises a scrub request right away. The request does not wait for the frame or the pass to end. A failing byte also bumps a small saturating error count that is reported as status. Software or a sequencer starts a pass with a byte length. The block then consumes exactly that many triplets, raises `done` and holds it until the next start. A clear pulse zeroes the error count.

All three inputs are valid/ready streams. A triplet is taken only in a cycle where all three streams are valid and a pass is running. The three ready outputs are always equal. Any producer may stall the whole compare by holding its valid low. A producer must not wait for ready before raising valid, because ready is derived from all three valids. Control and status pins are plain levels or pulses.

Top module: `cfg_verify_top`

## Requirements
- R1: While reset is held and after its release, `err_count` is 0, `scrub_req` and `done` are 0 and all three ready outputs are 0 until a pass is started.
- R2: The three ready outputs are always equal. They are 1 only while a pass is running and `rb_valid`, `gold_valid` and `mask_valid` are all 1. A triplet is consumed on a rising edge where they are 1.
- R3: A consumed triplet passes when, for every bit, `gold_data` equals `mask_data & rb_data`. A golden bit set to 1 under a mask bit of 0 is therefore a mismatch.
- R4: A consumed triplet that fails sets `scrub_req` to 1 for exactly the one cycle after the consuming edge. A passing triplet, or a cycle without consumption, leaves it at 0.
- R5: Each failing triplet raises `err_count` by one, and the count saturates at 15 (all ones of the 4-bit field).
- R6: A `clr` pulse makes `err_count` 0 on the next edge and takes priority over a failure consumed on the same edge; the scrub request for that failure is still raised. `start` does not change `err_count`.
- R7: A `start` pulse loads `byte_len`, clears `done` and begins a pass. The edge that consumes the `byte_len`-th triplet sets `done` to 1 and drops the readies to 0. `done` holds until the next `start`.
- R8: A `start` with `byte_len` equal to 0 sets `done` on the next edge, and no triplet is consumed.
- R9: When any one of the three valids is low, nothing is consumed. `err_count`, `scrub_req` and the pass progress are unaffected whatever data is present.
- R10: `byte_len` is 20 bits wide by default, covering passes of up to 1,048,575 bytes (more than a 368 KB image). Its upper bits are honoured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: begin a pass of `byte_len` bytes |
| byte_len | input | LEN_W (20) | Number of byte triplets in the pass |
| clr | input | 1 | Pulse: zero the error count |
| rb_valid | input | 1 | Readback stream valid |
| rb_ready | output | 1 | Readback stream ready |
| rb_data | input | DATA_W (8) | Readback byte |
| gold_valid | input | 1 | Golden stream valid |
| gold_ready | output | 1 | Golden stream ready |
| gold_data | input | DATA_W (8) | Golden (expected) byte |
| mask_valid | input | 1 | Mask stream valid |
| mask_ready | output | 1 | Mask stream ready |
| mask_data | input | DATA_W (8) | Mask byte, 1 = compare this bit |
| err_count | output | ERR_W (4) | Saturating count of failing bytes |
| scrub_req | output | 1 | One-cycle scrub request after a failing byte |
| done | output | 1 | Pass complete, held until next start |

## Verification
The bound checker watches on every cycle that the three readies agree and appear only with all valids present. It also checks that every failing consumed triplet is followed by a scrub pulse, that no pulse appears without one, that the error count moves by at most one and holds at 15, and that clear and done behave as stated. The compare rule itself, whether a pass ends after exactly the programmed number of bytes, the zero-length case and the honouring of the upper length bits can only be shown by the bench's scenarios. Those scenarios sweep every readback byte value against full, partial and shifting masks, with single-bit faults placed at each bit position.

// File: rtl/cv_pkg.sv
package cv_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_ERR_W  = 4;
  localparam int DEF_LEN_W  = 20;

  typedef enum int {
    STR_RB   = 0,
    STR_GOLD = 1,
    STR_MASK = 2,
    STR_NUM  = 3
  } stream_idx_e;
endpackage

// File: rtl/cv_join.sv
module cv_join #(
  parameter int N = 3
) (
  input  logic         enable,
  input  logic [N-1:0] valid,
  output logic [N-1:0] ready,
  output logic         fire
);
  logic all_valid;

  assign all_valid = &valid;
  assign fire      = enable & all_valid;

  for (genvar g = 0; g < N; g++) begin : g_rdy
    assign ready[g] = fire;
  end
endmodule

// File: rtl/cv_mask_cmp.sv
module cv_mask_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] rb,
  input  logic [W-1:0] gold,
  input  logic [W-1:0] mask,
  output logic         miss
);
  logic [W-1:0] bit_bad;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign bit_bad[b] = gold[b] ^ (mask[b] & rb[b]);
  end

  assign miss = |bit_bad;
endmodule

// File: rtl/cv_sat_cnt.sv
module cv_sat_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && count != TOP) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/cv_len_ctrl.sv
module cv_len_ctrl #(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             fire,
  output logic             busy,
  output logic             done
);
  logic [LEN_W-1:0] target;
  logic [LEN_W-1:0] seen;
  logic             last;

  assign last = (seen == target - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target <= '0;
      seen   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      target <= len;
      seen   <= '0;
      busy   <= (len != '0);
      done   <= (len == '0);
    end else if (fire) begin
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        seen <= seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_verify_top.sv
module cfg_verify_top
  import cv_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int ERR_W  = DEF_ERR_W,
  parameter int LEN_W  = DEF_LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic              clr,
  input  logic              rb_valid,
  output logic              rb_ready,
  input  logic [DATA_W-1:0] rb_data,
  input  logic              gold_valid,
  output logic              gold_ready,
  input  logic [DATA_W-1:0] gold_data,
  input  logic              mask_valid,
  output logic              mask_ready,
  input  logic [DATA_W-1:0] mask_data,
  output logic [ERR_W-1:0]  err_count,
  output logic              scrub_req,
  output logic              done
);
  localparam int NS = STR_NUM;

  logic [NS-1:0] valid_vec;
  logic [NS-1:0] ready_vec;
  logic          fire;
  logic          busy;
  logic          miss;

  assign valid_vec[STR_RB]   = rb_valid;
  assign valid_vec[STR_GOLD] = gold_valid;
  assign valid_vec[STR_MASK] = mask_valid;

  assign rb_ready   = ready_vec[STR_RB];
  assign gold_ready = ready_vec[STR_GOLD];
  assign mask_ready = ready_vec[STR_MASK];

  cv_join #(.N(NS)) u_join (
    .enable (busy),
    .valid  (valid_vec),
    .ready  (ready_vec),
    .fire   (fire)
  );

  cv_mask_cmp #(.W(DATA_W)) u_cmp (
    .rb   (rb_data),
    .gold (gold_data),
    .mask (mask_data),
    .miss (miss)
  );

  cv_sat_cnt #(.W(ERR_W)) u_errs (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (fire & miss),
    .count (err_count)
  );

  cv_len_ctrl #(.LEN_W(LEN_W)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .len   (byte_len),
    .fire  (fire),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) scrub_req <= 1'b0;
    else        scrub_req <= fire & miss;
  end
endmodule

// File: rtl/cv_verify_chk.sv
module cv_verify_chk #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              clr,
  input logic              rb_valid,
  input logic              rb_ready,
  input logic [DATA_W-1:0] rb_data,
  input logic              gold_valid,
  input logic              gold_ready,
  input logic [DATA_W-1:0] gold_data,
  input logic              mask_valid,
  input logic              mask_ready,
  input logic [DATA_W-1:0] mask_data,
  input logic [ERR_W-1:0]  err_count,
  input logic              scrub_req,
  input logic              done
);
  localparam logic [ERR_W-1:0] CMAX = {ERR_W{1'b1}};

  logic take;
  logic bad;
  assign take = rb_valid & rb_ready & gold_valid & gold_ready & mask_valid & mask_ready;
  assign bad  = gold_data != (mask_data & rb_data);

  p_ready_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_ready == gold_ready) && (gold_ready == mask_ready));

  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rb_ready |-> (rb_valid && gold_valid && mask_valid));

  p_scrub_after_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bad) |=> scrub_req);

  p_scrub_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> $past(take && bad));

  p_step_le_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CMAX && !clr) |=> err_count == CMAX);

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> err_count == '0);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rb_ready);

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind cfg_verify_top cv_verify_chk #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .clr        (clr),
  .rb_valid   (rb_valid),
  .rb_ready   (rb_ready),
  .rb_data    (rb_data),
  .gold_valid (gold_valid),
  .gold_ready (gold_ready),
  .gold_data  (gold_data),
  .mask_valid (mask_valid),
  .mask_ready (mask_ready),
  .mask_data  (mask_data),
  .err_count  (err_count),
  .scrub_req  (scrub_req),
  .done       (done)
);

// File: tb/cfg_verify_top_tb_top.sv
module cfg_verify_top_tb_top;
  localparam int LW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] byte_len = '0;
  logic          clr = 1'b0;
  logic          rb_valid = 1'b0, gold_valid = 1'b0, mask_valid = 1'b0;
  logic          rb_ready, gold_ready, mask_ready;
  logic [7:0]    rb_data = '0, gold_data = '0, mask_data = '0;
  logic [3:0]    err_count;
  logic          scrub_req, done;

  int nchk = 0;
  int nerr = 0;
  int m_err = 0;

  always #2 clk = ~clk;

  cfg_verify_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_len(byte_len), .clr(clr),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_data(rb_data),
    .gold_valid(gold_valid), .gold_ready(gold_ready), .gold_data(gold_data),
    .mask_valid(mask_valid), .mask_ready(mask_ready), .mask_data(mask_data),
    .err_count(err_count), .scrub_req(scrub_req), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic begin_pass(input logic [LW-1:0] len);
    @(negedge clk);
    start = 1'b1; byte_len = len;
    @(negedge clk);
    start = 1'b0;
  endtask

  // one triplet, then an idle cycle; checks ready, scrub pulse and count
  task automatic xfer(input logic [7:0] rb, input logic [7:0] msk,
                      input logic [7:0] gld, input bit clr_now);
    bit miss;
    @(negedge clk);
    rb_valid = 1; gold_valid = 1; mask_valid = 1;
    rb_data = rb; mask_data = msk; gold_data = gld; clr = clr_now;
    #1 check(rb_ready && gold_ready && mask_ready, "R2 ready with all valid", int'(rb_ready), 1);
    @(negedge clk);
    rb_valid = 0; gold_valid = 0; mask_valid = 0; clr = 0;
    miss = (gld != (msk & rb));
    if (clr_now) m_err = 0;
    else if (miss && m_err < 15) m_err++;
    check(scrub_req == miss, "R3/R4 scrub after compare", int'(scrub_req), int'(miss));
    check(int'(err_count) == m_err, "R5 error count", int'(err_count), m_err);
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(err_count == 0 && !scrub_req && !done, "R1 reset outputs", int'(err_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rb_valid = 1; gold_valid = 1; mask_valid = 1;
    #1 check(!rb_ready && !gold_ready && !mask_ready, "R1 idle ready low", int'(rb_ready), 0);
    rb_valid = 0; gold_valid = 0; mask_valid = 0;

    // Sweep: all readback values, full then varying masks, single-bit faults
    begin_pass(20'd512);
    for (int i = 0; i < 512; i++) begin
      logic [7:0] rb, msk, gld;
      rb  = 8'(i);
      msk = (i < 256) ? 8'hFF : (8'hA5 ^ 8'(i * 3));
      gld = msk & rb;
      if (i % 37 == 5) gld = gld ^ (8'h01 << (i % 8));
      xfer(rb, msk, gld, 1'b0);
      if (i < 511) check(!done, "R7 done not early", int'(done), 0);
    end
    check(done, "R7 done after 512 bytes", int'(done), 1);
    check(m_err == 14, "R5 sweep injected count", m_err, 14);
    @(negedge clk);
    rb_valid = 1; gold_valid = 1; mask_valid = 1; gold_data = 8'hFF; mask_data = 0;
    #1 check(!rb_ready, "R7 no consume after done", int'(rb_ready), 0);
    @(negedge clk);
    rb_valid = 0; gold_valid = 0; mask_valid = 0;
    check(int'(err_count) == m_err && done && !scrub_req, "R7 state held", int'(err_count), m_err);

    // Golden bit set under mask zero is a miss
    begin_pass(20'd2);
    check(int'(err_count) == m_err, "R6 start keeps count", int'(err_count), m_err);
    xfer(8'hFF, 8'h00, 8'h00, 1'b0);
    xfer(8'hFF, 8'h7F, 8'hFF, 1'b0);

    // Stalls: each single missing valid, with failing data present
    begin_pass(20'd3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rb_valid = (k != 0); gold_valid = (k != 1); mask_valid = (k != 2);
      rb_data = 8'h00; gold_data = 8'hFF; mask_data = 8'hFF;
      #1 check(!rb_ready && !gold_ready && !mask_ready, "R9 stall ready low", int'(rb_ready), 0);
      @(negedge clk);
      check(!scrub_req && int'(err_count) == m_err, "R9 stall no effect", int'(err_count), m_err);
      rb_valid = 0; gold_valid = 0; mask_valid = 0;
    end
    for (int k = 0; k < 3; k++) begin
      xfer(8'(k * 17), 8'hF0, 8'(k * 17) & 8'hF0, 1'b0);
      check(done == (k == 2), "R9 progress after stall", int'(done), int'(k == 2));
    end

    // Clear has priority over a concurrent miss
    begin_pass(20'd24);
    xfer(8'h12, 8'hFF, 8'h13, 1'b1);
    check(err_count == 0, "R6 clear wins", int'(err_count), 0);
    for (int k = 0; k < 20; k++) xfer(8'(k), 8'hFF, ~8'(k), 1'b0);
    check(err_count == 4'd15, "R5 saturates at 15", int'(err_count), 15);
    xfer(8'h3C, 8'h0F, 8'h0C, 1'b0);
    xfer(8'h3C, 8'h0F, 8'h0C, 1'b1);
    check(err_count == 0, "R6 clear on pass byte", int'(err_count), 0);
    check(!done, "R7 pass of 24 not yet done", int'(done), 0);

    // Zero length
    begin_pass(20'd0);
    check(done, "R8 zero length done", int'(done), 1);
    @(negedge clk);
    rb_valid = 1; gold_valid = 1; mask_valid = 1;
    #1 check(!rb_ready, "R8 nothing consumed", int'(rb_ready), 0);
    rb_valid = 0; gold_valid = 0; mask_valid = 0;

    // Upper length bit honoured
    begin_pass(20'h80000);
    check(!done, "R10 long pass started", int'(done), 0);
    for (int k = 0; k < 100; k++) xfer(8'hAA, 8'hFF, 8'hAA, 1'b0);
    check(!done, "R10 upper bits honoured", int'(done), 0);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule